// File: doc/BRIEF.md
# Privileged GS Base Swap Unit

This execution unit keeps two 64-bit pointers: the live GS segment base, which address generation reads on every GS-prefixed memory reference, and a shadow kernel pointer that sits behind a model-specific register address. A decoded instruction request arrives with its three opcode bytes and its qualifiers: the long-mode bit of the code segment, the current privilege level and the LOCK prefix. When those bytes name the swap operation and every qualifier allows it, the unit exchanges the two pointers in a single clock edge. If a qualifier forbids the swap, the unit reports a fault code and leaves both pointers alone.

The same unit answers MSR reads and writes aimed at the shadow pointer. Only privilege level 0 may access it. A write is accepted only when its value is a canonical virtual address, so the shadow pointer never holds a malformed address. An access to any other MSR address does not belong to this unit. The unit flags it as unhandled and does nothing else.

Results are registered. The done, fault, read-data and unhandled outputs describe the request sampled at the previous rising edge. The live base port shows the new value from that same edge onward.

Top module: `gsbase_swap_unit`

## Requirements
- R1: While reset is asserted and after it is released, both pointers are zero. `gs_base` reads 0 and `done`, `fault`, `msr_rdata` and `msr_unhandled` are all 0.
- R2: A request is a swap only when `insn_valid` is 1 and the bytes are `insn_b0`=0x0F, `insn_b1`=0x01 and `insn_b2`=0xF8. Any other byte pattern produces no done, no fault and no change of either pointer.
- R3: A legal swap (`cs_long`=1, `lock_pfx`=0, `cpl`=0) moves the old shadow value into `gs_base` and the old `gs_base` into the shadow, both at the same edge. `done` pulses for one cycle after that edge, and `gs_base` shows the new value from that edge onward.
- R4: A swap with `cs_long`=0 reports `fault`=2'b01 (invalid opcode), whatever the privilege level.
- R5: A swap with `cs_long`=1 and `lock_pfx`=1 reports `fault`=2'b01, even when `cpl` is not 0.
- R6: A swap with `cs_long`=1, `lock_pfx`=0 and `cpl` not 0 reports `fault`=2'b10 (general protection, error code 0), and neither pointer changes.
- R7: An MSR read (`msr_rd_en`=1, `msr_wr_en`=0) at `cpl`=0 to address 0xC0000102 returns the shadow value on `msr_rdata` with a `done` pulse. At every other time `msr_rdata` is 0.
- R8: An MSR write at `cpl`=0 to 0xC0000102 stores `msr_wdata` into the shadow when bits 63 down to VA_BITS-1 are all equal, and pulses `done`. A write takes priority over a read that is requested in the same cycle.
- R9: An MSR write whose value is not canonical reports `fault`=2'b10 and leaves the shadow unchanged.
- R10: An MSR read or write to 0xC0000102 at `cpl` not 0 reports `fault`=2'b10 and changes nothing.
- R11: An MSR access to any other address pulses `msr_unhandled` and produces no done, no fault and no state change.
- R12: `done` and a non-zero `fault` never occur together. When a swap and an MSR access arrive in the same cycle, the swap is served and the MSR access is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | A decoded instruction request is present |
| insn_b0 | input | 8 | First opcode byte |
| insn_b1 | input | 8 | Second opcode byte |
| insn_b2 | input | 8 | Third opcode byte |
| cs_long | input | 1 | Code segment long-mode bit (1 = 64-bit mode) |
| cpl | input | 2 | Current privilege level |
| lock_pfx | input | 1 | LOCK prefix present on the request |
| msr_rd_en | input | 1 | MSR read request |
| msr_wr_en | input | 1 | MSR write request |
| msr_addr | input | 32 | MSR address |
| msr_wdata | input | 64 | MSR write value |
| gs_base | output | 64 | Live GS base pointer |
| msr_rdata | output | 64 | MSR read result, valid with done |
| done | output | 1 | One-cycle pulse: swap or MSR access completed |
| fault | output | 2 | One-cycle fault code: 00 none, 01 invalid opcode, 10 general protection |
| msr_unhandled | output | 1 | One-cycle pulse: MSR address not owned by this unit |

## Verification
The bench builds the unit with its default parameters: VA_BITS=48 and shadow address 0xC0000102. With these values the canonical boundary sits at bit 47. Writes of 0x0000_7FFF_FFFF_FFFF and 0xFFFF_8000_0000_0000 land just inside the canonical range, and 0x0000_8000_0000_0000 lands just outside it. The fixed address also lets a neighbouring address such as 0xC0000101 exercise the unhandled path. A behavioural model tracks both pointers, and the bench compares every output against it on every cycle. The stimulus covers the order of the fault checks, the case where a swap and an MSR access collide, and a round trip of values through swaps and reads.

// File: rtl/gsbase_swap_unit.sv
module gsbase_swap_unit #(
  parameter int          VA_BITS    = 48,
  parameter logic [31:0] SHADOW_MSR = 32'hC000_0102
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [7:0]  insn_b0,
  input  logic [7:0]  insn_b1,
  input  logic [7:0]  insn_b2,
  input  logic        cs_long,
  input  logic [1:0]  cpl,
  input  logic        lock_pfx,
  input  logic        msr_rd_en,
  input  logic        msr_wr_en,
  input  logic [31:0] msr_addr,
  input  logic [63:0] msr_wdata,
  output logic [63:0] gs_base,
  output logic [63:0] msr_rdata,
  output logic        done,
  output logic [1:0]  fault,
  output logic        msr_unhandled
);
  localparam int          TOP  = 63;
  localparam int          CLO  = VA_BITS - 1;
  localparam logic [1:0]  F_NONE = 2'b00;
  localparam logic [1:0]  F_UD   = 2'b01;
  localparam logic [1:0]  F_GP   = 2'b10;

  function automatic logic canon(input logic [TOP:0] v);
    return (&v[TOP:CLO]) | ~(|v[TOP:CLO]);
  endfunction

  logic [63:0] shadow;
  logic [1:0]  fault_d;

  wire is_swap = insn_valid && insn_b0 == 8'h0F && insn_b1 == 8'h01 && insn_b2 == 8'hF8;
  wire msr_req = !is_swap && (msr_rd_en || msr_wr_en);
  wire msr_hit = msr_req && msr_addr == SHADOW_MSR;
  wire priv0   = cpl == 2'd0;

  always_comb begin
    fault_d = F_NONE;
    if (is_swap) begin
      if (!cs_long || lock_pfx) fault_d = F_UD;
      else if (!priv0)          fault_d = F_GP;
    end else if (msr_hit) begin
      if (!priv0)                            fault_d = F_GP;
      else if (msr_wr_en && !canon(msr_wdata)) fault_d = F_GP;
    end
  end

  wire swap_ok = is_swap && fault_d == F_NONE;
  wire wr_ok   = msr_hit && msr_wr_en && fault_d == F_NONE;
  wire rd_ok   = msr_hit && !msr_wr_en && fault_d == F_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gs_base       <= '0;
      shadow        <= '0;
      msr_rdata     <= '0;
      done          <= 1'b0;
      fault         <= F_NONE;
      msr_unhandled <= 1'b0;
    end else begin
      if (swap_ok) begin
        gs_base <= shadow;
        shadow  <= gs_base;
      end else if (wr_ok) begin
        shadow  <= msr_wdata;
      end
      msr_rdata     <= rd_ok ? shadow : '0;
      done          <= swap_ok || wr_ok || rd_ok;
      fault         <= fault_d;
      msr_unhandled <= msr_req && !msr_hit;
    end
  end

  AST_SWAP_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ok |=> gs_base == $past(shadow) && shadow == $past(gs_base) && done); // R3
  AST_MODE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    is_swap && !cs_long |=> fault == F_UD); // R4
  AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_d != F_NONE |=> gs_base == $past(gs_base) && shadow == $past(shadow)); // R6
  AST_SHADOW_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    canon(shadow) && canon(gs_base)); // R9
  AST_UNHANDLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    msr_unhandled |-> !done && fault == F_NONE); // R11
  AST_DONE_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault != F_NONE)); // R12
endmodule

// File: tb/gsbase_swap_unit_tb_top.sv
module gsbase_swap_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 0;
  logic [7:0]  insn_b0 = 0, insn_b1 = 0, insn_b2 = 0;
  logic        cs_long = 0, lock_pfx = 0, msr_rd_en = 0, msr_wr_en = 0;
  logic [1:0]  cpl = 0;
  logic [31:0] msr_addr = 0;
  logic [63:0] msr_wdata = 0;
  logic [63:0] gs_base, msr_rdata;
  logic        done, msr_unhandled;
  logic [1:0]  fault;

  int tests = 0, fails = 0, cycles = 0;
  logic [63:0] m_gs = 0, m_sh = 0, e_rd = 0;
  logic        e_done = 0, e_unh = 0;
  logic [1:0]  e_fault = 0;

  localparam logic [31:0] KMSR = 32'hC000_0102;

  always #10 clk = ~clk;

  gsbase_swap_unit dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 10000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic bit canon48(input logic [63:0] v);
    for (int i = 48; i < 64; i++) if (v[i] != v[47]) return 0;
    return 1;
  endfunction

  task automatic model();
    bit swp, hit, acc;
    swp = insn_valid && {insn_b0, insn_b1, insn_b2} == 24'h0F01F8;
    acc = !swp && (msr_rd_en || msr_wr_en);
    hit = acc && msr_addr == KMSR;
    e_done = 0; e_fault = 0; e_rd = 0; e_unh = acc && !hit;
    if (swp) begin
      if (!cs_long || lock_pfx) e_fault = 2'b01;
      else if (cpl != 0) e_fault = 2'b10;
      else begin
        logic [63:0] t;
        t = m_gs; m_gs = m_sh; m_sh = t; e_done = 1;
      end
    end else if (hit) begin
      if (cpl != 0) e_fault = 2'b10;
      else if (msr_wr_en) begin
        if (!canon48(msr_wdata)) e_fault = 2'b10;
        else begin m_sh = msr_wdata; e_done = 1; end
      end else begin
        e_rd = m_sh; e_done = 1;
      end
    end
  endtask

  task automatic compare(input string tag);
    tests++;
    if (gs_base !== m_gs || msr_rdata !== e_rd || done !== e_done ||
        fault !== e_fault || msr_unhandled !== e_unh) begin
      fails++;
      $display("FAIL %s: got gs=%h rd=%h done=%b fault=%b unh=%b exp gs=%h rd=%h done=%b fault=%b unh=%b",
               tag, gs_base, msr_rdata, done, fault, msr_unhandled,
               m_gs, e_rd, e_done, e_fault, e_unh);
    end
  endtask

  task automatic idle_inputs();
    insn_valid = 0; msr_rd_en = 0; msr_wr_en = 0; lock_pfx = 0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic swap(input logic [23:0] op, input logic lng, input logic [1:0] pl,
                      input logic lk, input string tag);
    insn_valid = 1; {insn_b0, insn_b1, insn_b2} = op;
    cs_long = lng; cpl = pl; lock_pfx = lk;
    step(tag);
  endtask

  task automatic msr(input logic wr, input logic [31:0] a, input logic [63:0] d,
                     input logic [1:0] pl, input string tag);
    msr_wr_en = wr; msr_rd_en = !wr; msr_addr = a; msr_wdata = d; cpl = pl;
    step(tag);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    step("R1 after reset");
    msr(0, KMSR, 0, 0, "R1 shadow zero read");
    swap(24'h0F01F9, 1, 0, 0, "R2 wrong byte2");
    swap(24'h0F00F8, 1, 0, 0, "R2 wrong byte1");
    msr(1, KMSR, 64'h0000_7FFF_FFFF_FFFF, 0, "R8 low canonical edge");
    msr(0, KMSR, 0, 0, "R7 read back");
    swap(24'h0F01F8, 1, 0, 0, "R3 legal swap");
    step("R3 idle after swap");
    msr(0, KMSR, 0, 0, "R3 shadow got old base");
    msr(1, KMSR, 64'hFFFF_8000_0000_0000, 0, "R8 high canonical edge");
    swap(24'h0F01F8, 1, 0, 0, "R3 second swap");
    swap(24'h0F01F8, 0, 0, 0, "R4 not long mode");
    swap(24'h0F01F8, 0, 3, 0, "R4 mode before privilege");
    swap(24'h0F01F8, 1, 0, 1, "R5 lock at cpl0");
    swap(24'h0F01F8, 1, 3, 1, "R5 lock before privilege");
    swap(24'h0F01F8, 1, 3, 0, "R6 cpl3");
    swap(24'h0F01F8, 1, 1, 0, "R6 cpl1");
    msr(1, KMSR, 64'h0000_8000_0000_0000, 0, "R9 just non-canonical");
    msr(1, KMSR, 64'h1234_0000_0000_0000, 0, "R9 non-canonical");
    msr(0, KMSR, 0, 0, "R9 shadow kept");
    msr(0, KMSR, 0, 2, "R10 read at cpl2");
    msr(1, KMSR, 64'h5, 3, "R10 write at cpl3");
    msr(0, KMSR, 0, 0, "R10 shadow kept");
    msr(1, 32'hC000_0101, 64'h77, 0, "R11 other address write");
    msr(0, 32'hC000_0100, 0, 0, "R11 other address read");
    msr_rd_en = 1; msr_wr_en = 1; msr_addr = KMSR; msr_wdata = 64'h42; cpl = 0;
    step("R8 write wins over read");
    insn_valid = 1; {insn_b0, insn_b1, insn_b2} = 24'h0F01F8; cs_long = 1; cpl = 0;
    msr_wr_en = 1; msr_addr = KMSR; msr_wdata = 64'h99;
    step("R12 swap beats msr");
    msr(0, KMSR, 0, 0, "R12 shadow after collision");
    step("R12 pulses end");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule